// File: doc/BRIEF.md
# Dual-Mode Pulse Multivibrator

This block replaces an RC-timed multivibrator with a counter clocked by the system clock. It has two modes. In free-running mode, the output Q is a square wave with a half-period of `HALF_CYC` clock cycles. In one-shot mode, a single trigger edge produces one high pulse on Q that lasts `HALF_CYC` cycles. The counter value plays the part of the external resistor and capacitor. A complemented output is always available. A tap output runs at twice the frequency of Q while the oscillator is running.

Free-running mode can be requested through either of two enable pins, one active-high and one active-low. A one-shot starts on a rising edge of the positive trigger pin or on a falling edge of the negative trigger pin. A trigger edge that arrives while a pulse is already running has no effect. The one exception is a rising edge on the positive trigger that lands in the same cycle as a rising edge on the retrigger pin: this restarts the width count and stretches the pulse. Every enable and trigger pin passes through a two-flop synchronizer before it is used, so each response appears two clocks after the input is sampled.

`HALF_CYC` must be even and at least 2.

Top module: `pulse_multivib`

## Requirements
- R1: While `rst` is high, `q`=0, `q_n`=1 and `osc`=0, whatever the other inputs do.
- R2: `q_n` is always the complement of `q`.
- R3: Free-running mode is requested when `run_hi`=1 or `run_n`=0. If an enable is applied before clock edge E0, `q` goes high at edge E2. From then on, `q` toggles every `HALF_CYC` cycles.
- R4: While free-running, `osc` goes high together with each `q` toggle and toggles again `HALF_CYC/2` cycles later. At all other times, `osc` is 0.
- R5: When the request is withdrawn before edge E_D, the half-period that is running completes normally. `q` and `osc` then fall at the first half-period boundary at or after edge E_D+2, and stay low.
- R6: A 0-to-1 change on `trig_rise` applied before edge E0, while idle and not free-running, sets `q` high from E2 to E(2+HALF_CYC). The pulse width does not depend on how long the trigger is held.
- R7: A 1-to-0 change on `trig_fall` produces the same pulse as R6. The return of `trig_fall` to 1 does nothing.
- R8: A trigger edge on either pin that is detected while a pulse is running, without a coincident retrigger edge, leaves the pulse end unchanged.
- R9: If `trig_rise` and `retrig` both rise before edge E_d during a running pulse, the count restarts at E_d+2 and `q` falls at E(d+2+HALF_CYC). A rise on `retrig` alone does nothing.
- R10: Trigger edges that arrive during free-running mode do not change `q` or `osc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| run_hi | input | 1 | Free-running request, active high |
| run_n | input | 1 | Free-running request, active low |
| trig_rise | input | 1 | One-shot trigger, rising edge |
| trig_fall | input | 1 | One-shot trigger, falling edge |
| retrig | input | 1 | Retrigger qualifier, rising edge coincident with `trig_rise` |
| q | output | 1 | Main output |
| q_n | output | 1 | Complement of `q` |
| osc | output | 1 | Double-rate oscillator tap |

## Verification
The hardest case to reach from the ports is a retrigger that lands on the very cycle the width count expires. Only there does the priority between restarting and ending the pulse decide the result. The bench sweeps the retrigger delay from the second cycle up to `HALF_CYC`, so the last step lands exactly on the final count. The same sweep is repeated with an ignored trigger and with a retrigger edge alone. A second sweep withdraws the free-running request at every cycle across three half-periods, so that both high and low half-periods are seen ending.

// File: rtl/pulse_multivib.sv
module pulse_multivib #(
  parameter int HALF_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run_hi,
  input  logic run_n,
  input  logic trig_rise,
  input  logic trig_fall,
  input  logic retrig,
  output logic q,
  output logic q_n,
  output logic osc
);
  localparam int CW = $clog2(HALF_CYC);
  localparam logic [CW-1:0] LOAD = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] MID  = CW'(HALF_CYC / 2);
  localparam logic [4:0] IN_IDLE = 5'b01010;

  typedef enum logic [1:0] {IDLE = 2'd0, ASTAB = 2'd1, MONO = 2'd2} mode_t;

  logic [4:0] s1, s2;
  logic [2:0] s3;
  logic [CW-1:0] cnt;
  mode_t mode;
  logic q_r, osc_r;

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      s1 <= IN_IDLE;
      s2 <= IN_IDLE;
      s3 <= IN_IDLE[4:2];
    end else begin
      s1 <= {retrig, trig_fall, trig_rise, run_n, run_hi};
      s2 <= s1;
      s3 <= s2[4:2];
    end

  logic run_en, rise_t, fall_t, rise_r, fire, ret_hit;
  assign run_en  = s2[0] | ~s2[1];
  assign rise_t  = s2[2] & ~s3[0];
  assign fall_t  = ~s2[3] & s3[1];
  assign rise_r  = s2[4] & ~s3[2];
  assign fire    = rise_t | fall_t;
  assign ret_hit = rise_t & rise_r;

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      mode  <= IDLE;
      cnt   <= '0;
      q_r   <= 1'b0;
      osc_r <= 1'b0;
    end else begin
      case (mode)
        IDLE: begin
          if (run_en) begin
            mode  <= ASTAB;
            cnt   <= LOAD;
            q_r   <= 1'b1;
            osc_r <= 1'b1;
          end else if (fire) begin
            mode <= MONO;
            cnt  <= LOAD;
            q_r  <= 1'b1;
          end
        end
        ASTAB: begin
          if (cnt == '0) begin
            cnt <= LOAD;
            if (run_en) begin
              q_r   <= ~q_r;
              osc_r <= ~osc_r;
            end else begin
              mode  <= IDLE;
              q_r   <= 1'b0;
              osc_r <= 1'b0;
            end
          end else begin
            cnt <= cnt - 1'b1;
            if (cnt == MID) osc_r <= ~osc_r;
          end
        end
        MONO: begin
          if (ret_hit) cnt <= LOAD;
          else if (cnt == '0) begin
            mode <= IDLE;
            q_r  <= 1'b0;
          end else cnt <= cnt - 1'b1;
        end
        default: mode <= IDLE;
      endcase
    end

  assign q   = q_r;
  assign q_n = ~q_r;
  assign osc = osc_r;
endmodule

module pulse_multivib_chk #(
  parameter int HALF_CYC = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          q,
  input logic          q_n,
  input logic          osc,
  input logic [1:0]    mode,
  input logic [CW-1:0] cnt,
  input logic          fire,
  input logic          ret_hit
);
  localparam logic [1:0] M_ASTAB = 2'd1;
  localparam logic [1:0] M_MONO  = 2'd2;

  int run_len;
  always_ff @(posedge clk or posedge rst)
    if (rst) run_len <= 0;
    else run_len <= q ? run_len + 1 : 0;

  AST_RESET_OUTS: assert property (@(posedge clk) rst |-> (!q && q_n && !osc)); // R1
  AST_MIN_HIGH: assert property (@(posedge clk) disable iff (rst) $fell(q) |-> run_len >= HALF_CYC); // R6
  AST_OSC_MONO_LOW: assert property (@(posedge clk) disable iff (rst) (mode == M_MONO) |-> !osc); // R4
  AST_OSC_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (mode == M_ASTAB && $past(mode) == M_ASTAB && q != $past(q)) |-> osc); // R4
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (mode == M_MONO && fire && !ret_hit && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R8
  AST_RETRIG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (mode == M_MONO && ret_hit) |=> (cnt == CW'(HALF_CYC - 1))); // R9
  AST_ASTAB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == M_ASTAB && fire && cnt != '0) |=> (mode == M_ASTAB)); // R10
endmodule

bind pulse_multivib pulse_multivib_chk #(.HALF_CYC(HALF_CYC), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .q(q), .q_n(q_n), .osc(osc), .mode(mode),
  .cnt(cnt), .fire(fire), .ret_hit(ret_hit)
);

// File: tb/pulse_multivib_bench.sv
module pulse_multivib_bench;
  localparam int N = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, rhi = 1'b0, rn = 1'b1, tr = 1'b0, tf = 1'b1, rt = 1'b0;
  logic q, qn, osc;
  int errs = 0, checks = 0;
  bit done = 1'b0;

  pulse_multivib #(.HALF_CYC(N)) u_pulse_multivib (
    .clk(clk), .rst(rst), .run_hi(rhi), .run_n(rn), .trig_rise(tr),
    .trig_fall(tf), .retrig(rt), .q(q), .q_n(qn), .osc(osc)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic outs(input string tq, input string to, input logic eq, input logic eo);
    chk(tq, q, eq);
    chk("R2 q_n", qn, ~q);
    chk(to, osc, eo);
  endtask

  task automatic idle_in();
    rhi = 0; rn = 1; tr = 0; tf = 1; rt = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_in();
    rst = 1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      #1 outs("R1 q", "R1 osc", 1'b0, 1'b0);
    end
    rst = 0;
    repeat (3) @(negedge clk);
  endtask

  // R6 / R7: one pulse of N cycles regardless of hold time
  task automatic mono(input bit neg, input int h);
    do_reset();
    if (neg) tf = 0; else tr = 1;
    for (int k = 0; k < 2 * N + 6; k++) begin
      step();
      if (k == h - 1) begin tr = 0; tf = 1; end
      outs(neg ? "R7 q" : "R6 q", "R4 osc", (k >= 2 && k < N + 2), 1'b0);
    end
  endtask

  // kind 0: ignored trigger (R8), 1: retrigger (R9), 2: retrig pin alone (R9)
  task automatic second(input int kind, input int d);
    int hi_end;
    hi_end = (kind == 1) ? d + N + 1 : N + 1;
    do_reset();
    tr = 1;
    for (int k = 0; k < 3 * N + 6; k++) begin
      step();
      if (k == 0) tr = 0;
      if (k == d - 1) begin
        if (kind != 2) tr = 1;
        if (kind != 0) rt = 1;
      end
      if (k == d) begin tr = 0; rt = 0; end
      outs(kind == 0 ? "R8 q" : "R9 q", "R4 osc", (k >= 2 && k <= hi_end), 1'b0);
    end
  endtask

  // R3 / R4 / R5 / R10: free-running with request dropped before edge D
  task automatic astab(input bit lowpol, input int dd);
    int j, s, t;
    logic eq, eo;
    j = (dd + N - 1) / N;
    if (j < 1) j = 1;
    s = 2 + j * N;
    do_reset();
    if (lowpol) rn = 0; else rhi = 1;
    for (int k = 0; k < s + N + 3; k++) begin
      step();
      if (k == dd - 1) begin rhi = 0; rn = 1; end
      if (k == 3) tr = 1;
      if (k == 4) tr = 0;
      if (k < 2 || k >= s) begin
        eq = 0; eo = 0;
      end else begin
        t = k - 2;
        eq = ((t / N) % 2) == 0;
        eo = ((t / (N / 2)) % 2) == 0;
      end
      outs(k >= s ? "R5 q" : (k >= 5 && k <= 8) ? "R10 q" : "R3 q",
           k >= s ? "R5 osc" : "R4 osc", eq, eo);
    end
  endtask

  initial begin
    #1 outs("R1 q", "R1 osc", 1'b0, 1'b0);
    for (int pol = 0; pol < 2; pol++)
      for (int h = 1; h <= 2 * N + 2; h++) mono(pol[0], h);
    for (int kind = 0; kind < 3; kind++)
      for (int d = 2; d <= N; d++) second(kind, d);
    for (int pol = 0; pol < 2; pol++)
      for (int dd = 1; dd <= 3 * N; dd++) astab(pol[0], dd);
    // R1: reset overrides active request and trigger
    do_reset();
    rhi = 1; tr = 1;
    repeat (5) step();
    rst = 1;
    #1 outs("R1 q", "R1 osc", 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step();
      outs("R1 q", "R1 osc", 1'b0, 1'b0);
    end
    rst = 0;
    idle_in();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule